// File: doc/BRIEF.md
# Parallel Tap Frequency-to-Code Converter

This block turns the phase taps of a ring oscillator into an oversampled multi-bit code stream. Each tap is an asynchronous square wave whose rate follows an analog quantity upstream. On every sampling clock the block registers each tap, marks the taps whose level has changed since the previous sample, and adds those marks into one unsigned code word. Each slice on its own acts as a first-order noise-shaping quantizer that needs no feedback path. Adding the slices of all taps raises resolution and spreads idle tones.

Each tap first passes through a parameterized resynchronizer chain. A second sample register follows, and the edge mark is the XOR of the two sample registers. The code word is registered. After a synchronous reset the code stays at zero and the valid strobe stays low until every pipeline stage holds real samples. From then on valid is high on every clock. A decimation filter outside this block consumes the stream.

Top module: `tapfreq_conv`

## Requirements
- R1: While `rst_n` is low, and on the clock edge that follows it, `code_o` is 0 and `valid_o` is 0.
- R2: Count clock edges with `rst_n` high from 1 after reset release. `valid_o` rises exactly after edge SYNC_STAGES+3 and stays high until the next reset. Before that edge `code_o` is 0.
- R3: Once valid, `code_o` (unsigned binary) equals the number of taps whose sampled level at edge k-SYNC_STAGES-1 differs from the level sampled at edge k-SYNC_STAGES-2, where k is the edge that loads `code_o`.
- R4: `code_o` never exceeds NUM_TAPS. When every tap toggles between every pair of samples, `code_o` equals NUM_TAPS.
- R5: When all taps hold a constant level for SYNC_STAGES+3 or more sampling edges, `code_o` is 0.
- R6: With SYNC_STAGES = 0 the resynchronizer is bypassed. The code then reflects the toggles between the samples at edges k-1 and k-2, and valid rises after edge 3.
- R7: After the pipeline has been flushed with static taps, the sum of all valid codes over a window equals the number of tap level changes applied in that window, within ±NUM_TAPS. This holds when each tap changes at most once per sampling period.
- R8: The code width CODE_W defaults to ceil(log2(NUM_TAPS+1)): 4 bits for 8 taps and 2 bits for 3 taps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| taps_i | input | NUM_TAPS | Asynchronous ring-oscillator phase taps |
| code_o | output | CODE_W | Count of taps that toggled, unsigned |
| valid_o | output | 1 | High when `code_o` carries a real sample |

## Verification
The taps are driven with constant levels, with every tap toggling on every sample, with ring-style square waves swept over half-periods 1 to 6 and phase steps 0 to 3, and with a pseudo-random pattern. Constant levels separate a real edge detector from one that leaks level into the code. All-toggle driving hits the top code value and exposes adder truncation. The swept square waves check per-tap independence and the exact pipeline latency. The random pattern reaches tap combinations that the regular waves never produce. A second instance with the resynchronizer bypassed and a reset in mid-run check the priming count and the variant selection.

// File: rtl/tapfreq_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the tap frequency converter.
// Assumes: nothing beyond standard elaboration-time arithmetic.
package tapfreq_pkg;

    // Width needed to hold a count from 0 up to taps inclusive.
    function automatic int sum_width(input int taps);
        return (taps < 1) ? 1 : $clog2(taps + 1);
    endfunction

    // Phase of the priming controller.
    typedef enum logic {
        PH_FILL = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

endpackage

// File: rtl/tap_sync.sv
`timescale 1ns/1ps
// Resynchronizer chain for one asynchronous tap.
// STAGES = 0 gives a direct pass-through. Otherwise STAGES flops in series
// limit metastability. Assumes the tap changes at most once per clock.
module tap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    generate
        if (STAGES == 0) begin : g_bypass
            // Purpose: pass the tap straight through when no resync is wanted.
            assign q = d;
        end else begin : g_chain
            logic [STAGES-1:0] sr;

            // Purpose: shift the tap level through the resync flops.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sr <= '0;
                end else begin
                    sr[0] <= d;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end

            assign q = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/tap_edge_slice.sv
`timescale 1ns/1ps
// One first-order quantizer slice: two sample registers in series and an
// XOR that marks a level change between consecutive samples.
// Assumes the input is already synchronous to clk.
module tap_edge_slice (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_s,
    output logic toggled
);

    logic smp_now;
    logic smp_old;

    // Purpose: hold the current and the previous sample of the tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp_now <= 1'b0;
            smp_old <= 1'b0;
        end else begin
            smp_now <= tap_s;
            smp_old <= smp_now;
        end
    end

    // Purpose: flag a level change between the two samples.
    always_comb begin
        toggled = smp_now ^ smp_old;
    end

endmodule

// File: rtl/tap_adder.sv
`timescale 1ns/1ps
// Combinational population count of the per-slice toggle flags.
// Assumes W is wide enough to hold N (the top derives it that way).
module tap_adder #(
    parameter int N = 8,
    parameter int W = 4
) (
    input  logic [N-1:0] flags,
    output logic [W-1:0] total
);

    // Purpose: add every toggle flag into one unsigned count.
    always_comb begin
        total = '0;
        for (int i = 0; i < N; i++) begin
            total = total + W'(flags[i]);
        end
    end

endmodule

// File: rtl/prime_ctrl.sv
`timescale 1ns/1ps
// Tracks pipeline fill after reset. primed goes high once FILL edges
// have passed with reset released, and stays high until the next reset.
// Assumes FILL >= 1.
module prime_ctrl
    import tapfreq_pkg::*;
#(
    parameter int FILL = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic primed
);

    localparam int CW = $clog2(FILL + 1);

    phase_e        phase;
    logic [CW-1:0] fill_cnt;

    // Purpose: count fill edges and move to run phase when full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_FILL;
            fill_cnt <= '0;
        end else if (phase == PH_FILL) begin
            fill_cnt <= fill_cnt + CW'(1);
            if (fill_cnt == CW'(FILL - 1)) begin
                phase <= PH_RUN;
            end
        end
    end

    // Purpose: expose the run phase as the primed flag.
    always_comb begin
        primed = (phase == PH_RUN);
    end

endmodule

// File: rtl/tapfreq_conv.sv
`timescale 1ns/1ps
// Parallel frequency-to-code converter. One resync chain plus one edge
// slice per oscillator tap. The toggle flags are summed each clock into a
// registered code word. The code is forced to 0, with valid low, until
// every stage holds samples taken after reset.
// Assumes the taps change at most once per sampling period.
module tapfreq_conv
    import tapfreq_pkg::*;
#(
    parameter int NUM_TAPS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = sum_width(NUM_TAPS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps_i,
    output logic [CODE_W-1:0]   code_o,
    output logic                valid_o
);

    // Edges until a flag built only from post-reset samples exists.
    localparam int FILL = SYNC_STAGES + 2;

    logic [NUM_TAPS-1:0] tap_s;
    logic [NUM_TAPS-1:0] flags;
    logic [CODE_W-1:0]   sum;
    logic                primed;

    generate
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            tap_sync #(
                .STAGES (SYNC_STAGES)
            ) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (taps_i[t]),
                .q     (tap_s[t])
            );

            tap_edge_slice u_slice (
                .clk     (clk),
                .rst_n   (rst_n),
                .tap_s   (tap_s[t]),
                .toggled (flags[t])
            );
        end
    endgenerate

    tap_adder #(
        .N (NUM_TAPS),
        .W (CODE_W)
    ) u_adder (
        .flags (flags),
        .total (sum)
    );

    prime_ctrl #(
        .FILL (FILL)
    ) u_prime (
        .clk    (clk),
        .rst_n  (rst_n),
        .primed (primed)
    );

    // Purpose: register the code word, gated to zero while priming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_o  <= '0;
            valid_o <= 1'b0;
        end else begin
            code_o  <= primed ? sum : '0;
            valid_o <= primed;
        end
    end

endmodule

// File: rtl/tapfreq_conv_chk.sv
`timescale 1ns/1ps
// Property checker for tapfreq_conv, attached by bind. It keeps its own
// edge and stability counters and does not look inside the design.
module tapfreq_conv_chk #(
    parameter int NUM_TAPS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int CODE_W      = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [NUM_TAPS-1:0] taps_i,
    input logic [CODE_W-1:0]   code_o,
    input logic                valid_o
);

    localparam int PRIME = SYNC_STAGES + 3;
    localparam int EW    = $clog2(PRIME + 2) + 1;

    logic [EW-1:0]       edge_cnt;
    logic [EW-1:0]       calm_cnt;
    logic [NUM_TAPS-1:0] taps_q;

    // Purpose: count edges since reset release and edges of constant taps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_cnt <= '0;
            calm_cnt <= '0;
            taps_q   <= '0;
        end else begin
            taps_q <= taps_i;
            if (edge_cnt < EW'(PRIME)) edge_cnt <= edge_cnt + EW'(1);
            if (taps_i != taps_q)          calm_cnt <= '0;
            else if (calm_cnt < EW'(PRIME)) calm_cnt <= calm_cnt + EW'(1);
        end
    end

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (code_o == '0 && !valid_o));

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> code_o == '0);

    p_prime_time_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o == (edge_cnt >= EW'(PRIME)));

    p_valid_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        32'(code_o) <= NUM_TAPS);

    p_static_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (calm_cnt >= EW'(PRIME) && edge_cnt >= EW'(PRIME)) |-> code_o == '0);

endmodule

bind tapfreq_conv tapfreq_conv_chk #(
    .NUM_TAPS    (NUM_TAPS),
    .SYNC_STAGES (SYNC_STAGES),
    .CODE_W      (CODE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .taps_i  (taps_i),
    .code_o  (code_o),
    .valid_o (valid_o)
);

// File: tb/test_tapfreq_conv.sv
`timescale 1ns/1ps
// Bench: an 8-tap, 2-stage instance and a 3-tap bypass instance share the
// tap vector. Expected codes come from the latency rule in the requirements.
module test_tapfreq_conv;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] taps = '0;
    logic [3:0] code_a;
    logic       valid_a;
    logic [1:0] code_b;
    logic       valid_b;

    int   checks = 0;
    int   errors = 0;
    int   n = 0;
    bit   done = 0;
    logic [7:0] hist [16];
    int   win_sum;
    int   win_trans;

    always #2 clk = ~clk;

    tapfreq_conv #(.NUM_TAPS(8), .SYNC_STAGES(2)) i_tapfreq_conv (
        .clk(clk), .rst_n(rst_n), .taps_i(taps), .code_o(code_a), .valid_o(valid_a));

    tapfreq_conv #(.NUM_TAPS(3), .SYNC_STAGES(0)) i_tapfreq_conv_s0 (
        .clk(clk), .rst_n(rst_n), .taps_i(taps[2:0]), .code_o(code_b), .valid_o(valid_b));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s t=%0t n=%0d actual=%0d expected=%0d", req, $time, n, act, exp);
        end
    endtask

    // Apply one tap vector at a falling edge, pass one rising edge, check.
    task automatic step(input logic [7:0] v, input logic r, input string tag);
        int ea, eb;
        win_trans += $countones(v ^ taps);
        taps  = v;
        rst_n = r;
        if (!r) n = 0;
        @(posedge clk);
        if (rst_n) begin
            n++;
            hist[n & 15] = taps;
        end
        @(negedge clk);
        if (!rst_n) begin
            chk("R1 code", int'(code_a), 0);
            chk("R1 valid", int'(valid_a), 0);
        end else if (n < 5) begin
            chk("R2 code before prime", int'(code_a), 0);
            chk("R2 valid before prime", int'(valid_a), 0);
        end else begin
            ea = $countones(hist[(n-3) & 15] ^ hist[(n-4) & 15]);
            chk({tag, " code"}, int'(code_a), ea);
            chk("R2 valid held", int'(valid_a), 1);
        end
        if (rst_n && n >= 3) begin
            eb = $countones((hist[(n-1) & 15] ^ hist[(n-2) & 15]) & 8'h07);
            chk("R6 bypass code", int'(code_b), eb);
            chk("R6 bypass valid", int'(valid_b), 1);
        end else begin
            chk("R6 bypass idle code", int'(code_b), 0);
            chk("R6 bypass idle valid", int'(valid_b), 0);
        end
        if (valid_a) win_sum += int'(code_a);
    endtask

    task automatic flush_window(input string tag);
        logic [7:0] hold;
        int d;
        hold = taps;
        for (int i = 0; i < 6; i++) step(hold, 1'b1, "R5");
        d = win_sum - win_trans;
        checks++;
        if (d > 8 || d < -8) begin
            errors++;
            $display("FAIL R7 %s actual=%0d expected=%0d", tag, win_sum, win_trans);
        end
    endtask

    function automatic logic [7:0] ring(input int t, input int half, input int ph);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = ((((t + i * ph) / half) % 2) == 1);
        return r;
    endfunction

    initial begin
        logic [15:0] lfsr;
        win_sum = 0;
        win_trans = 0;
        for (int i = 0; i < 16; i++) hist[i] = '0;
        @(negedge clk);
        chk("R8 width 8 taps", $bits(code_a), 4);
        chk("R8 width 3 taps", $bits(code_b), 2);
        // R1: reset held while taps toggle.
        for (int i = 0; i < 4; i++) step(8'hFF * (i % 2), 1'b0, "R1");
        // R2/R4: prime under full toggling, then code = NUM_TAPS.
        for (int i = 0; i < 12; i++) step(taps ^ 8'hFF, 1'b1, "R4");
        chk("R4 full-scale", int'(code_a), 8);
        // R5: static taps.
        for (int i = 0; i < 10; i++) step(8'hA5, 1'b1, "R5");
        chk("R5 static", int'(code_a), 0);
        // R3/R7: ring square waves swept over half-period and phase step.
        for (int half = 1; half <= 6; half++) begin
            for (int ph = 0; ph < 4; ph++) begin
                win_sum = 0;
                win_trans = 0;
                for (int t = 0; t < 36; t++) step(ring(t, half, ph), 1'b1, "R3 ring");
                flush_window("ring window");
            end
        end
        // R3/R7: pseudo-random taps.
        lfsr = 16'hACE1;
        win_sum = 0;
        win_trans = 0;
        for (int t = 0; t < 200; t++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[7:0], 1'b1, "R3 random");
        end
        flush_window("random window");
        // R1/R2: reset in mid-run, then re-prime under toggling.
        step(8'h0F, 1'b0, "R1");
        step(8'hF0, 1'b0, "R1");
        for (int i = 0; i < 10; i++) step(taps ^ 8'h3C, 1'b1, "R4");
        chk("R4 partial toggle", int'(code_a), 4);
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule